// File: doc/BRIEF.md
# Two-Wire Bus Transaction Engine

This block is a single-controller engine for an open-drain two-wire serial bus (clock line and data line). A host issues one command at a time: begin a frame, send a byte, receive a byte and answer it with an acknowledge or a not-acknowledge, or end the frame. The engine breaks each command into bit slots, generates every clock pulse itself, and reports the result through a received-data register and an acknowledge flag.

The bus side is made of two pull-low enables and two raw line samples. Each sample passes through a two-stage synchronizer before use. Bit timing comes from a quarter-bit divider. The default divider gives 100 kbit/s from a 50 MHz clock. A target may hold the clock line low to slow the transfer, and the engine waits until it reads the line high before it times the high half of the bit. After a byte is refused, the host ends the frame with a stop or opens a new one with a repeated start. The bus stays owned across a repeated start.

Top module: `twi_xfer_ctrl`

## Requirements
- R1: After reset both pull-low enables (`scl_lo_o`, `sda_lo_o`, 1 = pull low) are 0, and `busy_o` and `done_o` are 0.
- R2: Command code 0 (begin frame) makes the data line fall while the clock line is high. This works from an idle bus and when the clock line starts low.
- R3: Command code 4 (end frame) makes the data line rise while the clock line is high. Both enables are 0 when the command completes.
- R4: During the bit slots of a byte command, the data line never changes while the clock line is high.
- R5: Command code 1 (send byte) shifts out `wdata_i` in 8 clock pulses, most significant bit first. The engine releases the data line on a 9th pulse and samples it there. `ack_o` is then 1 if the line was low and 0 if it was high.
- R6: Codes 2 and 3 (receive byte) sample 8 bits, most significant bit first, into `rdata_o`. On the 9th pulse the engine pulls the data line low for code 2 and leaves it released for code 3.
- R7: When a target holds the clock line low, the engine waits. It starts timing the high half of the bit only after it reads the line high, so the received data stays correct.
- R8: `done_o` is high for exactly one cycle per accepted command. In that cycle `busy_o` falls, and `busy_o` was high in the cycle before.
- R9: A strobe on `cmd_go_i` is ignored while `busy_o` is high, and so are codes 5 to 7. Neither produces bus activity or a `done_o` pulse.
- R10: With no stretching, every clock high phase lasts at least one quarter period and every clock low phase lasts at least two quarter periods.
- R11: After a refused byte (`ack_o` = 0), a begin-frame command produces a repeated start edge without first producing a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_go_i | input | 1 | Command strobe, taken when idle |
| cmd_i | input | 3 | Command code (0 begin, 1 send, 2 receive+ACK, 3 receive+NACK, 4 end) |
| wdata_i | input | DATA_W | Byte to send |
| rdata_o | output | DATA_W | Last received byte |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ack_o | output | 1 | 1 when the last sent byte was acknowledged |
| scl_i | input | 1 | Clock line level as seen on the bus |
| sda_i | input | 1 | Data line level as seen on the bus |
| scl_lo_o | output | 1 | Pull clock line low when 1 |
| sda_lo_o | output | 1 | Pull data line low when 1 |

## Verification
The bench targets the acknowledge slot and the repeated start that follows a refused byte. A design that drove the data line during the 9th pulse, or that inverted the acknowledge sense, would report the wrong `ack_o`, and one that restored the data line in the wrong order would record a stop edge before the start. Clock stretching is applied during a receive. A design that did not wait for the line to read high would sample the data bits too early and return a corrupted byte. The bench also sends a strobe while busy and an undefined code; an engine that accepted either would leave an extra edge on the bus or an extra `done_o` pulse.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [2:0] {
        CMD_BEGIN   = 3'd0,
        CMD_SEND    = 3'd1,
        CMD_RD_ACK  = 3'd2,
        CMD_RD_NACK = 3'd3,
        CMD_END     = 3'd4
    } twi_cmd_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BIT   = 2'd1,
        OP_STOP  = 2'd2
    } twi_op_e;

    typedef struct packed {
        logic       active;
        twi_op_e    kind;
        logic [1:0] phase;
        logic       scl_lo;
        logic       sda_lo;
        logic       smp;
        logic       done;
    } bit_state_t;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '1;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/twi_quarter_timer.sv
module twi_quarter_timer #(
    parameter int DIV = 125
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic hold_i,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 2;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (at_last) begin
            cnt_d = hold_i ? cnt_q : '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign tick_o = run_i && at_last && !hold_i;
endmodule

// File: rtl/twi_bit_engine.sv
module twi_bit_engine
    import twi_pkg::*;
#(
    parameter int DIV = 125
) (
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    req_i,
    input  twi_op_e kind_i,
    input  logic    val_i,
    input  logic    scl_s_i,
    input  logic    sda_s_i,
    output logic    done_o,
    output logic    smp_o,
    output logic    scl_lo_o,
    output logic    sda_lo_o
);
    bit_state_t st_d, st_q;
    logic       tick;
    logic       hold;

    // Stall the end of the rise phase until the clock line reads high.
    assign hold = st_q.active && (st_q.phase == 2'd1) && !scl_s_i;

    twi_quarter_timer #(.DIV(DIV)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (st_q.active),
        .hold_i (hold),
        .tick_o (tick)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.active) begin
            if (req_i) begin
                st_d.active = 1'b1;
                st_d.kind   = kind_i;
                st_d.phase  = 2'd0;
                case (kind_i)
                    OP_START: st_d.sda_lo = 1'b0;
                    OP_BIT: begin
                        st_d.scl_lo = 1'b1;
                        st_d.sda_lo = ~val_i;
                    end
                    OP_STOP: begin
                        st_d.scl_lo = 1'b1;
                        st_d.sda_lo = 1'b1;
                    end
                    default: st_d.active = 1'b0;
                endcase
            end
        end else if (tick) begin
            case (st_q.phase)
                2'd0: begin
                    st_d.phase  = 2'd1;
                    st_d.scl_lo = 1'b0;
                end
                2'd1: begin
                    st_d.phase = 2'd2;
                    if (st_q.kind == OP_START) st_d.sda_lo = 1'b1;
                    if (st_q.kind == OP_STOP)  st_d.sda_lo = 1'b0;
                end
                2'd2: begin
                    st_d.phase = 2'd3;
                    if (st_q.kind == OP_BIT)   st_d.smp    = sda_s_i;
                    if (st_q.kind != OP_STOP)  st_d.scl_lo = 1'b1;
                end
                default: begin
                    st_d.phase  = 2'd0;
                    st_d.active = 1'b0;
                    st_d.done   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.kind   <= OP_START;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o   = st_q.done;
    assign smp_o    = st_q.smp;
    assign scl_lo_o = st_q.scl_lo;
    assign sda_lo_o = st_q.sda_lo;

    p_stretch_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active && st_q.phase == 2'd1 && !scl_s_i) |=> (st_q.phase == 2'd1));

    p_sda_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active && st_q.kind == OP_BIT && st_q.phase != 2'd3) |=> $stable(st_q.sda_lo));

    p_start_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active && st_q.kind == OP_START && $rose(st_q.sda_lo)) |-> !st_q.scl_lo);

    p_stop_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.done && st_q.kind == OP_STOP) |-> (!st_q.scl_lo && !st_q.sda_lo));
endmodule

// File: rtl/twi_xfer_ctrl.sv
module twi_xfer_ctrl
    import twi_pkg::*;
#(
    parameter int QUARTER_DIV = 125,
    parameter int DATA_W      = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_go_i,
    input  logic [2:0]        cmd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              ack_o,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_lo_o,
    output logic              sda_lo_o
);
    localparam int IW = $clog2(DATA_W + 1);
    localparam logic [IW-1:0] ACK_SLOT = IW'(DATA_W);

    typedef struct packed {
        logic              busy;
        twi_cmd_e          cmd;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rdata;
        logic              ack;
        logic              done;
        logic              req;
        twi_op_e           kind;
        logic              val;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [1:0]        line_s;
    logic              bit_done;
    logic              bit_smp;
    logic              is_read;
    logic              cmd_ok;
    logic [IW-1:0]     idx_n;
    logic [DATA_W-1:0] sh_n;

    twi_sync #(.W(2), .STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({scl_i, sda_i}),
        .q_o    (line_s)
    );

    twi_bit_engine #(.DIV(QUARTER_DIV)) u_bits (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (st_q.req),
        .kind_i   (st_q.kind),
        .val_i    (st_q.val),
        .scl_s_i  (line_s[1]),
        .sda_s_i  (line_s[0]),
        .done_o   (bit_done),
        .smp_o    (bit_smp),
        .scl_lo_o (scl_lo_o),
        .sda_lo_o (sda_lo_o)
    );

    assign is_read = (st_q.cmd == CMD_RD_ACK) || (st_q.cmd == CMD_RD_NACK);
    assign cmd_ok  = (cmd_i <= 3'd4);
    assign idx_n   = st_q.idx + 1'b1;
    assign sh_n    = {st_q.sh[DATA_W-2:0], is_read ? bit_smp : 1'b0};

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.req  = 1'b0;
        if (!st_q.busy) begin
            if (cmd_go_i && cmd_ok) begin
                st_d.busy = 1'b1;
                st_d.cmd  = twi_cmd_e'(cmd_i);
                st_d.idx  = '0;
                st_d.req  = 1'b1;
                st_d.val  = 1'b1;
                case (twi_cmd_e'(cmd_i))
                    CMD_BEGIN: st_d.kind = OP_START;
                    CMD_END:   st_d.kind = OP_STOP;
                    CMD_SEND: begin
                        st_d.kind = OP_BIT;
                        st_d.sh   = wdata_i;
                        st_d.val  = wdata_i[DATA_W-1];
                    end
                    default:   st_d.kind = OP_BIT;
                endcase
            end
        end else if (bit_done) begin
            if (st_q.kind != OP_BIT || st_q.idx == ACK_SLOT) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                if (st_q.cmd == CMD_SEND) st_d.ack   = ~bit_smp;
                if (is_read)              st_d.rdata = st_q.sh;
            end else begin
                st_d.sh   = sh_n;
                st_d.idx  = idx_n;
                st_d.req  = 1'b1;
                st_d.kind = OP_BIT;
                if (idx_n == ACK_SLOT) begin
                    st_d.val = is_read ? (st_q.cmd == CMD_RD_NACK) : 1'b1;
                end else begin
                    st_d.val = is_read ? 1'b1 : sh_n[DATA_W-1];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.cmd  <= CMD_BEGIN;
            st_q.kind <= OP_START;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
    assign busy_o  = st_q.busy;
    assign done_o  = st_q.done;
    assign ack_o   = st_q.ack;

    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.done |=> !st_q.done);

    p_done_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.done |-> $past(st_q.busy));

    p_ignore_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && cmd_go_i && !bit_done) |=> ($stable(st_q.cmd) && $stable(st_q.idx) && st_q.busy));

    p_bad_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.busy && cmd_go_i && cmd_i > 3'd4) |=> !st_q.busy);
endmodule

// File: tb/twi_xfer_ctrl_tb_top.sv
`timescale 1ns/1ps
module twi_xfer_ctrl_tb_top;
    localparam int DIV     = 4;
    localparam int STRETCH = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_go = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       busy, done, ack;
    logic       scl_lo, sda_lo;
    logic       scl_bus, sda_bus;

    // behavioural target
    int         next_pos = 0;
    int         pos = 0;
    int         hold_cnt = 0;
    logic       tgt_tx = 1'b0;
    logic       tgt_ack = 1'b1;
    logic [7:0] tgt_byte = 8'h00;
    logic       stretch_en = 1'b0;
    logic       tgt_sda_lo;

    int         ev_q[$];   // 1 = start edge, 2 = stop edge
    logic       bits_q[$];
    int         done_cnt = 0;
    int         n_chk = 0, n_fail = 0;
    int         min_high = 1000000, min_low = 1000000, max_low = 0;
    int         run_len = 0;
    logic       run_valid = 1'b0;
    logic       scl_prev = 1'b1, sda_prev = 1'b1, busy_prev = 1'b0;
    logic       finished = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        if (!tgt_tx) tgt_sda_lo = (next_pos == 9) && tgt_ack;
        else         tgt_sda_lo = (next_pos >= 1) && (next_pos <= 8) && !tgt_byte[8-next_pos];
    end

    assign scl_bus = !scl_lo && (hold_cnt == 0);
    assign sda_bus = !sda_lo && !tgt_sda_lo;

    twi_xfer_ctrl #(.QUARTER_DIV(DIV), .DATA_W(8)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .cmd_go_i (cmd_go),
        .cmd_i    (cmd),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .busy_o   (busy),
        .done_o   (done),
        .ack_o    (ack),
        .scl_i    (scl_bus),
        .sda_i    (sda_bus),
        .scl_lo_o (scl_lo),
        .sda_lo_o (sda_lo)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock reference: bus events, bit slots, phase lengths, done/busy
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_cnt > 0) hold_cnt--;
            if (scl_prev && scl_bus && (sda_prev != sda_bus)) begin
                ev_q.push_back(sda_bus ? 2 : 1);
                next_pos = 0;
                pos = 0;
            end
            if (!scl_prev && scl_bus) begin
                bits_q.push_back(sda_bus);
                pos = (pos == 9) ? 1 : pos + 1;
            end
            if (scl_prev && !scl_bus) begin
                next_pos = (pos == 9 || pos == 0) ? 1 : pos + 1;
                if (stretch_en) hold_cnt = STRETCH;
            end
            if (scl_bus == scl_prev) begin
                run_len++;
            end else begin
                if (run_valid) begin
                    if (scl_prev) begin
                        if (run_len < min_high) min_high = run_len;
                    end else begin
                        if (!stretch_en && run_len < min_low) min_low = run_len;
                        if (run_len > max_low) max_low = run_len;
                    end
                end
                run_valid = 1'b1;
                run_len = 1;
            end
            if (done) begin
                done_cnt++;
                chk("R8 done with busy low", int'(busy), 0);
                chk("R8 busy before done", int'(busy_prev), 1);
            end
            scl_prev  = scl_bus;
            sda_prev  = sda_bus;
            busy_prev = busy;
        end
    end

    task automatic launch(input logic [2:0] c, input logic [7:0] d);
        @(negedge clk);
        ev_q.delete();
        bits_q.delete();
        cmd_go = 1'b1;
        cmd    = c;
        wdata  = d;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic wait_done(input int base);
        int t = 0;
        while (done_cnt == base && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 5000) chk("R8 command completion timeout", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    function automatic int rx_byte();
        logic [7:0] b = 8'h00;
        for (int i = 0; i < 8; i++) b = {b[6:0], bits_q[i]};
        return int'(b);
    endfunction

    task automatic run_cmd(input logic [2:0] c, input logic [7:0] d);
        int base = done_cnt;
        launch(c, d);
        wait_done(base);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scl_lo after reset", int'(scl_lo), 0);
        chk("R1 sda_lo after reset", int'(sda_lo), 0);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);

        // R2: begin from idle bus
        run_cmd(3'd0, 8'h00);
        chk("R2 one edge", ev_q.size(), 1);
        if (ev_q.size() > 0) chk("R2 start edge", ev_q[0], 1);
        chk("R2 no bit pulses", bits_q.size(), 0);

        // R5: send with acknowledge
        tgt_ack = 1'b1;
        run_cmd(3'd1, 8'hA5);
        chk("R5 nine pulses", bits_q.size(), 9);
        if (bits_q.size() == 9) begin
            chk("R5 byte on bus", rx_byte(), 8'hA5);
            chk("R5 ack slot low", int'(bits_q[8]), 0);
        end
        chk("R5 ack flag", int'(ack), 1);
        chk("R4 no edge inside data bits", ev_q.size(), 0);

        // R5: send refused, controller must release data in slot 9
        tgt_ack = 1'b0;
        run_cmd(3'd1, 8'h3C);
        if (bits_q.size() == 9) begin
            chk("R5 byte on bus refused", rx_byte(), 8'h3C);
            chk("R5 slot 9 released", int'(bits_q[8]), 1);
        end else chk("R5 nine pulses refused", bits_q.size(), 9);
        chk("R5 nack flag", int'(ack), 0);
        chk("R4 no edge inside refused byte", ev_q.size(), 0);

        // R11: repeated start after refusal
        run_cmd(3'd0, 8'h00);
        chk("R11 single edge", ev_q.size(), 1);
        if (ev_q.size() > 0) chk("R11 repeated start edge", ev_q[0], 1);

        // R9: strobe while busy is ignored
        tgt_ack = 1'b1;
        base = done_cnt;
        launch(3'd1, 8'h5A);
        repeat (10) @(negedge clk);
        cmd_go = 1'b1;
        cmd    = 3'd4;
        @(negedge clk);
        cmd_go = 1'b0;
        wait_done(base);
        repeat (20) @(negedge clk);
        chk("R9 one done for busy strobe", done_cnt - base, 1);
        chk("R9 no stop edge from ignored strobe", ev_q.size(), 0);
        chk("R9 idle after send", int'(busy), 0);
        if (bits_q.size() == 9) chk("R5 byte 5A", rx_byte(), 8'h5A);
        else chk("R9 pulse count", bits_q.size(), 9);

        // R6: receive with acknowledge
        tgt_tx   = 1'b1;
        tgt_byte = 8'hC3;
        run_cmd(3'd2, 8'h00);
        chk("R6 rdata C3", int'(rdata), 8'hC3);
        if (bits_q.size() == 9) chk("R6 controller ack low", int'(bits_q[8]), 0);
        else chk("R6 nine pulses", bits_q.size(), 9);
        chk("R4 no edge inside read", ev_q.size(), 0);

        // R7 + R6: receive with stretching, then not-acknowledge
        tgt_byte   = 8'h96;
        stretch_en = 1'b1;
        run_cmd(3'd3, 8'h00);
        stretch_en = 1'b0;
        chk("R7 rdata under stretch", int'(rdata), 8'h96);
        if (bits_q.size() == 9) chk("R6 controller nack high", int'(bits_q[8]), 1);
        else chk("R7 nine pulses", bits_q.size(), 9);
        chk("R7 stretch observed", int'(max_low >= STRETCH), 1);
        chk("R7 high phase after stretch", int'(min_high >= DIV), 1);

        // R3: end frame
        tgt_tx = 1'b0;
        run_cmd(3'd4, 8'h00);
        chk("R3 single edge", ev_q.size(), 1);
        if (ev_q.size() > 0) chk("R3 stop edge", ev_q[0], 2);
        chk("R3 scl released", int'(scl_lo), 0);
        chk("R3 sda released", int'(sda_lo), 0);
        chk("R3 bus idle high", int'(scl_bus && sda_bus), 1);

        // R9: undefined code
        base = done_cnt;
        launch(3'd7, 8'hFF);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (busy) begin
                chk("R9 undefined code busy", int'(busy), 0);
                break;
            end
        end
        chk("R9 undefined code done", done_cnt - base, 0);
        chk("R9 undefined code bus", ev_q.size() + bits_q.size(), 0);

        // R10: phase lengths over the whole run
        chk("R10 min high", int'(min_high >= DIV), 1);
        chk("R10 min low", int'(min_low >= 2 * DIV), 1);
        chk("R8 total done pulses", done_cnt, 8);

        summary();
    end
endmodule